// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the bus pins of a byte-wide flash array and turns host write cycles into array commands. Each write cycle is framed by a strobe: the address is captured when the strobe rises and the data when it falls. The completed cycle is then checked against a small state machine. Commands only count when they come after a fixed two-write unlock key, which is data AAh at low address 5555h followed by data 55h at low address 2AAAh. Some commands need one key and some need two. Stray writes therefore cannot start a program or an erase.

The recognised commands are:
- byte program
- whole-array erase
- sector erase
- boot-area lockout
- entry to and exit from an identification mode

Each command leaves the block as a single-clock pulse. Program and sector erase also carry their latched address, and program carries its data byte. In identification mode the read data output returns fixed codes chosen by the read address. Writes are ignored while the array reports busy and during a power-up hold-off after reset. Pulling reset low abandons any partial sequence and leaves identification mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is low, and directly after it, all command pulses are 0, the identification flag is 0, and the latched program address and data are 0.
- R2: The unlock key is AAh written to an address whose low 15 bits are 5555h, followed by 55h written to low address 2AAAh. Address bits above bit 14 are ignored in every key and command compare.
- R3: A key followed by A0h at low address 5555h arms programming. The next write of any address and data raises progPulse for one cycle. On that cycle progAddr holds the full address of that write and progData holds its data.
- R4: Key, 80h at 5555h, key, then 10h at 5555h raises chipErasePulse.
- R5: Key, 80h at 5555h, key, then 40h at 5555h raises lockPulse.
- R6: Key, 80h at 5555h, key, then 30h at any address raises sectErasePulse. sectorAddr is the address present when the strobe of that last write rose; the data is the value present on the last strobe-high cycle.
- R7: Key then 90h at 5555h sets idMode. While idMode is 1, idData is DAh at address 0, 0Bh at address 1, {7'b0, bootLocked} at address 2, and 00h at any other address. While idMode is 0, idData is 00h.
- R8: idMode is cleared by a key followed by F0h at 5555h, or by one F0h write to any address when programming is not armed.
- R9: A write that does not match the expected address and data for the current step returns the sequencer to idle and raises no command.
- R10: A write whose strobe falls while busy is 1 has no effect, and the sequence step is kept.
- R11: Writes ending within HOLDOFF_CYCLES clocks of reset release have no effect.
- R12: Reset low in the middle of a sequence abandons it, so a following write completes no command.
- R13: Command pulses last one clock, at most one is high at a time, and a pulse appears on the cycle after the one in which a strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe; one write lasts from its rise to its fall |
| addr | input | ADDR_W | Write address, also the identification read address |
| wrData | input | 8 | Write data |
| busy | input | 1 | Array operation in progress; writes are ignored |
| bootLocked | input | 1 | Current boot-area lockout state, reported in identification mode |
| progPulse | output | 1 | Byte program command pulse |
| progAddr | output | ADDR_W | Target address of the last program command |
| progData | output | 8 | Data of the last program command |
| chipErasePulse | output | 1 | Whole-array erase pulse |
| sectErasePulse | output | 1 | Sector erase pulse |
| sectorAddr | output | ADDR_W | Address of the last sector erase command |
| lockPulse | output | 1 | Boot-area lockout pulse |
| idMode | output | 1 | Identification mode flag |
| idData | output | 8 | Identification read data |

## Verification
The assertions assume that every write strobe stays high for at least one clock and low for at least one clock between writes. They also assume that busy does not change during the cycle a strobe falls. As a result, two command pulses can never be adjacent, and each pulse can be traced back to a falling strobe two samples earlier. The stimulus drives all inputs on the falling clock edge. Strobes are one or two cycles high, separated by at least one low cycle. busy is only changed between writes. Random sequences are built from correct command scripts, with random upper address bits, random program targets and random sector addresses. In some of them a single step has its data corrupted. Directed cases cover the busy, hold-off, reset and mid-strobe address cases.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_A    = 8'hAA;
  localparam logic [7:0] KEY_B    = 8'h55;
  localparam logic [7:0] OP_PROG  = 8'hA0;
  localparam logic [7:0] OP_EXT   = 8'h80;
  localparam logic [7:0] OP_ID    = 8'h90;
  localparam logic [7:0] OP_EXIT  = 8'hF0;
  localparam logic [7:0] OP_CHIP  = 8'h10;
  localparam logic [7:0] OP_LOCK  = 8'h40;
  localparam logic [7:0] OP_SECT  = 8'h30;
  localparam logic [7:0] ID_MAKER = 8'hDA;
  localparam logic [7:0] ID_PART  = 8'h0B;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_EXT,
    SEQ_EXT_KEY1,
    SEQ_EXT_KEY2,
    SEQ_PROG
  } seq_state_t;

  typedef struct packed {
    logic prog;
    logic chipErase;
    logic sectErase;
    logic lock;
    logic idSet;
    logic idClr;
  } cmd_strobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrDone,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  output cmd_strobe_t       strobe
);

  seq_state_t state, nextState;
  logic hitA, hitB;

  assign hitA = (cmdAddr[CMP_W-1:0] == KEY_ADDR_A);
  assign hitB = (cmdAddr[CMP_W-1:0] == KEY_ADDR_B);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (wrDone) begin
      nextState = SEQ_IDLE;
      if (state == SEQ_PROG) begin
        strobe.prog = 1'b1;
      end else if (cmdData == OP_EXIT) begin
        strobe.idClr = 1'b1;
      end else begin
        case (state)
          SEQ_IDLE:
            if (hitA && cmdData == KEY_A) nextState = SEQ_KEY1;
          SEQ_KEY1:
            if (hitB && cmdData == KEY_B) nextState = SEQ_KEY2;
          SEQ_KEY2:
            if (hitA) begin
              if (cmdData == OP_PROG)     nextState = SEQ_PROG;
              else if (cmdData == OP_EXT) nextState = SEQ_EXT;
              else if (cmdData == OP_ID)  strobe.idSet = 1'b1;
            end
          SEQ_EXT:
            if (hitA && cmdData == KEY_A) nextState = SEQ_EXT_KEY1;
          SEQ_EXT_KEY1:
            if (hitB && cmdData == KEY_B) nextState = SEQ_EXT_KEY2;
          SEQ_EXT_KEY2:
            if (cmdData == OP_SECT)              strobe.sectErase = 1'b1;
            else if (hitA && cmdData == OP_CHIP) strobe.chipErase = 1'b1;
            else if (hitA && cmdData == OP_LOCK) strobe.lock      = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int HOLDOFF_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  logic              bootLocked,
  input  cmd_strobe_t       strobe,
  output logic              wrDone,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [7:0]        cmdData,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              chipErasePulse,
  output logic              sectErasePulse,
  output logic [ADDR_W-1:0] sectorAddr,
  output logic              lockPulse,
  output logic              idMode,
  output logic [7:0]        idData
);

  localparam int HOLD_W = $clog2(HOLDOFF_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLDOFF_CYCLES);

  logic              wrPrev;
  logic [HOLD_W-1:0] holdCnt;
  logic              holdReady;

  assign holdReady = (holdCnt == HOLD_END);
  assign wrDone    = wrPrev && !wrEn && !busy && holdReady;

  // Write framing: address at strobe rise, data on last strobe-high cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      cmdAddr <= '0;
      cmdData <= '0;
    end else begin
      wrPrev <= wrEn;
      if (wrEn && !wrPrev) cmdAddr <= addr;
      if (wrEn)            cmdData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdCnt <= '0;
    else if (!holdReady) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPulse      <= 1'b0;
      chipErasePulse <= 1'b0;
      sectErasePulse <= 1'b0;
      lockPulse      <= 1'b0;
      progAddr       <= '0;
      progData       <= '0;
      sectorAddr     <= '0;
      idMode         <= 1'b0;
    end else begin
      progPulse      <= strobe.prog;
      chipErasePulse <= strobe.chipErase;
      sectErasePulse <= strobe.sectErase;
      lockPulse      <= strobe.lock;
      if (strobe.prog) begin
        progAddr <= cmdAddr;
        progData <= cmdData;
      end
      if (strobe.sectErase) sectorAddr <= cmdAddr;
      if (strobe.idSet)      idMode <= 1'b1;
      else if (strobe.idClr) idMode <= 1'b0;
    end
  end

  always_comb begin
    idData = 8'h00;
    if (idMode) begin
      if (addr == ADDR_W'(0))      idData = ID_MAKER;
      else if (addr == ADDR_W'(1)) idData = ID_PART;
      else if (addr == ADDR_W'(2)) idData = {7'b0, bootLocked};
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int HOLDOFF_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  logic              bootLocked,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              chipErasePulse,
  output logic              sectErasePulse,
  output logic [ADDR_W-1:0] sectorAddr,
  output logic              lockPulse,
  output logic              idMode,
  output logic [7:0]        idData
);

  cmd_strobe_t       strobe;
  logic              wrDone;
  logic [ADDR_W-1:0] cmdAddr;
  logic [7:0]        cmdData;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrDone  (wrDone),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .strobe  (strobe)
  );

  flash_cmd_dpath #(.ADDR_W(ADDR_W), .HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .wrEn           (wrEn),
    .addr           (addr),
    .wrData         (wrData),
    .busy           (busy),
    .bootLocked     (bootLocked),
    .strobe         (strobe),
    .wrDone         (wrDone),
    .cmdAddr        (cmdAddr),
    .cmdData        (cmdData),
    .progPulse      (progPulse),
    .progAddr       (progAddr),
    .progData       (progData),
    .chipErasePulse (chipErasePulse),
    .sectErasePulse (sectErasePulse),
    .sectorAddr     (sectorAddr),
    .lockPulse      (lockPulse),
    .idMode         (idMode),
    .idData         (idData)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int HOLDOFF_CYCLES = 250000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              busy,
  input logic [ADDR_W-1:0] addr,
  input logic              idMode,
  input logic [7:0]        idData,
  input logic              progPulse,
  input logic              chipErasePulse,
  input logic              sectErasePulse,
  input logic              lockPulse
);

  logic        anyCmd;
  logic [31:0] sinceRst;

  assign anyCmd = progPulse | chipErasePulse | sectErasePulse | lockPulse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      sinceRst <= '0;
    else if (sinceRst != '1)        sinceRst <= sinceRst + 1'b1;
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progPulse, chipErasePulse, sectErasePulse, lockPulse})); // R13

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |=> !anyCmd); // R13

  AST_CMD_AFTER_STROBE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> (!$past(wrEn) && $past(wrEn, 2))); // R13

  AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> !$past(busy)); // R10

  AST_NO_CMD_IN_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> (sinceRst > 32'(HOLDOFF_CYCLES))); // R11

  AST_ID_MAKER_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && addr == ADDR_W'(0)) |-> (idData == ID_MAKER)); // R7

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !idMode |-> (idData == 8'h00)); // R7

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
  .ADDR_W(ADDR_W),
  .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .wrEn           (wrEn),
  .busy           (busy),
  .addr           (addr),
  .idMode         (idMode),
  .idData         (idData),
  .progPulse      (progPulse),
  .chipErasePulse (chipErasePulse),
  .sectErasePulse (sectErasePulse),
  .lockPulse      (lockPulse)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

  localparam int AW   = 18;
  localparam int HOLD = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wrData = '0;
  logic          busy = 1'b0;
  logic          bootLocked = 1'b0;
  logic          progPulse, chipErasePulse, sectErasePulse, lockPulse, idMode;
  logic [AW-1:0] progAddr, sectorAddr;
  logic [7:0]    progData, idData;

  int checks = 0;
  int failures = 0;
  logic modelId = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .HOLDOFF_CYCLES(HOLD)) u_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .busy(busy), .bootLocked(bootLocked), .progPulse(progPulse),
    .progAddr(progAddr), .progData(progData), .chipErasePulse(chipErasePulse),
    .sectErasePulse(sectErasePulse), .sectorAddr(sectorAddr),
    .lockPulse(lockPulse), .idMode(idMode), .idData(idData)
  );

  function automatic logic [3:0] pulses();
    return {progPulse, chipErasePulse, sectErasePulse, lockPulse};
  endfunction

  function automatic logic [7:0] expId(logic m, logic [AW-1:0] a, logic lk);
    if (!m)      return 8'h00;
    if (a == 0)  return 8'hDA;
    if (a == 1)  return 8'h0B;
    if (a == 2)  return {7'b0, lk};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doWrite2(input logic [AW-1:0] a1, input logic [7:0] d1,
                          input logic [AW-1:0] a2, input logic [7:0] d2);
    addr = a1; wrData = d1; wrEn = 1'b1;
    @(negedge clk);
    addr = a2; wrData = d2;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic key(input logic [2:0] hi);
    doWrite({hi, 15'h5555}, 8'hAA);
    doWrite({hi, 15'h2AAA}, 8'h55);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelId = 1'b0;
  endtask

  task automatic settle();
    repeat (HOLD + 2) @(negedge clk);
  endtask

  // cmd: 0 prog, 1 chip, 2 sect, 3 lock, 4 id entry, 5 id exit by key, 6 id exit single
  task automatic sendSeq(input int cmd, input int bad);
    logic [AW-1:0] sa [6];
    logic [7:0]    sd [6];
    logic [2:0]    hi;
    logic [3:0]    fin;
    int            n;
    string         tag;
    hi = 3'($urandom);
    sa[0] = {hi, 15'h5555}; sd[0] = 8'hAA;
    sa[1] = {hi, 15'h2AAA}; sd[1] = 8'h55;
    sa[2] = {hi, 15'h5555}; sd[2] = 8'h80;
    sa[3] = {hi, 15'h5555}; sd[3] = 8'hAA;
    sa[4] = {hi, 15'h2AAA}; sd[4] = 8'h55;
    sa[5] = {hi, 15'h5555}; sd[5] = 8'h10;
    n = 6; fin = 4'b0100; tag = "R4";
    case (cmd)
      0: begin sd[2] = 8'hA0; sa[3] = AW'($urandom); sd[3] = 8'($urandom);
               n = (bad > 0) ? 3 : 4; fin = 4'b1000; tag = "R3"; end
      2: begin sd[5] = 8'h30; sa[5] = AW'($urandom); fin = 4'b0010; tag = "R6"; end
      3: begin sd[5] = 8'h40; fin = 4'b0001; tag = "R5"; end
      4: begin sd[2] = 8'h90; n = 3; fin = 4'b0000; tag = "R7"; end
      5: begin sd[2] = 8'hF0; n = 3; fin = 4'b0000; tag = "R8"; end
      6: begin sa[0] = AW'($urandom); sd[0] = 8'hF0; n = 1; fin = 4'b0000; tag = "R8"; end
      default: ;
    endcase
    if (bad > 0) sd[bad-1] = sd[bad-1] ^ 8'h01;
    for (int i = 0; i < n; i++) begin
      doWrite(sa[i], sd[i]);
      if (bad > 0) chk("R9 corrupted sequence pulses", 32'(pulses()), 32'(0));
      else chk({tag, " pulses"}, 32'(pulses()), (i == n - 1) ? 32'(fin) : 32'(0));
    end
    if (bad == 0) begin
      if (cmd == 0) begin
        chk("R3 progAddr", 32'(progAddr), 32'(sa[3]));
        chk("R3 progData", 32'(progData), 32'(sd[3]));
      end
      if (cmd == 2) chk("R6 sectorAddr", 32'(sectorAddr), 32'(sa[5]));
      if (cmd == 4) modelId = 1'b1;
      if (cmd == 6) modelId = 1'b0;
    end
    if (cmd == 5 && bad != 3) modelId = 1'b0;
    chk({tag, " idMode"}, 32'(idMode), 32'(modelId));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 pulses in reset", 32'(pulses()), 32'(0));
    chk("R1 idMode in reset", 32'(idMode), 32'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 progAddr after reset", 32'(progAddr), 32'(0));
    chk("R1 progData after reset", 32'(progData), 32'(0));

    // R11 hold-off: a full program sequence right after reset is ignored
    key(3'd0);
    doWrite(18'h05555, 8'hA0);
    doWrite(18'h00123, 8'h45);
    chk("R11 no program in hold-off", 32'(pulses()), 32'(0));
    settle();
    key(3'd0);
    doWrite(18'h05555, 8'hA0);
    doWrite(18'h00123, 8'h45);
    chk("R11 program after hold-off", 32'(pulses()), 32'(4'b1000));

    // R2/R3 upper bits ignored in key, target keeps full address
    key(3'b101);
    doWrite(18'h3D555, 8'hA0);
    doWrite(18'h21234, 8'h5C);
    chk("R3 program pulse", 32'(pulses()), 32'(4'b1000));
    chk("R3 progAddr", 32'(progAddr), 32'(18'h21234));
    chk("R3 progData", 32'(progData), 32'(8'h5C));
    @(negedge clk);
    chk("R13 pulse lasts one cycle", 32'(pulses()), 32'(0));
    chk("R13 progAddr held", 32'(progAddr), 32'(18'h21234));

    // R2 a low-bit mismatch breaks the key
    doWrite(18'h05554, 8'hAA);
    doWrite(18'h02AAA, 8'h55);
    doWrite(18'h05555, 8'hA0);
    doWrite(18'h00010, 8'h11);
    chk("R2 low bit mismatch", 32'(pulses()), 32'(0));

    // R4 chip erase, R5 lockout
    key(3'd0); doWrite(18'h05555, 8'h80); key(3'd2); doWrite(18'h05555, 8'h10);
    chk("R4 chip erase pulse", 32'(pulses()), 32'(4'b0100));
    key(3'd0); doWrite(18'h05555, 8'h80); key(3'd0); doWrite(18'h15555, 8'h40);
    chk("R5 lock pulse", 32'(pulses()), 32'(4'b0001));

    // R6 sector address taken at strobe rise, data at strobe end
    key(3'd0); doWrite(18'h05555, 8'h80); key(3'd0);
    doWrite2(18'h3A123, 8'h77, 18'h01000, 8'h30);
    chk("R6 sector erase pulse", 32'(pulses()), 32'(4'b0010));
    chk("R6 sectorAddr at strobe rise", 32'(sectorAddr), 32'(18'h3A123));

    // R7 identification reads
    key(3'd0); doWrite(18'h05555, 8'h90);
    chk("R7 idMode set", 32'(idMode), 32'(1));
    addr = 18'h0; #1 chk("R7 maker code", 32'(idData), 32'(8'hDA));
    addr = 18'h1; #1 chk("R7 part code", 32'(idData), 32'(8'h0B));
    bootLocked = 1'b1;
    addr = 18'h2; #1 chk("R7 lock bit set", 32'(idData), 32'(8'h01));
    bootLocked = 1'b0;
    #1 chk("R7 lock bit clear", 32'(idData), 32'(8'h00));
    addr = 18'h3; #1 chk("R7 other address", 32'(idData), 32'(8'h00));

    // R8 single-write exit, then keyed exit
    doWrite(18'h1ABCD, 8'hF0);
    chk("R8 single F0 exit", 32'(idMode), 32'(0));
    addr = 18'h0; #1 chk("R7 idData quiet outside mode", 32'(idData), 32'(8'h00));
    key(3'd0); doWrite(18'h05555, 8'h90);
    key(3'd0); doWrite(18'h05555, 8'hF0);
    chk("R8 keyed exit", 32'(idMode), 32'(0));

    // R9 mismatched third write, then wrong second key
    key(3'd0); doWrite(18'h05556, 8'hA0); doWrite(18'h05555, 8'h33);
    chk("R9 wrong command address", 32'(pulses()), 32'(0));
    key(3'd0); doWrite(18'h05555, 8'h80);
    doWrite(18'h05555, 8'hAA); doWrite(18'h02AAA, 8'h56); doWrite(18'h05555, 8'h10);
    chk("R9 wrong second key", 32'(pulses()), 32'(0));

    // R10 busy writes ignored and step kept
    key(3'd0);
    busy = 1'b1; doWrite(18'h05555, 8'hA0); busy = 1'b0;
    doWrite(18'h05555, 8'hA0);
    chk("R10 busy write ignored", 32'(pulses()), 32'(0));
    busy = 1'b1; doWrite(18'h00777, 8'h99); busy = 1'b0;
    chk("R10 no pulse while busy", 32'(pulses()), 32'(0));
    doWrite(18'h00888, 8'h66);
    chk("R10 program after busy", 32'(pulses()), 32'(4'b1000));
    chk("R10 progData after busy", 32'(progData), 32'(8'h66));

    // R12 reset mid-sequence
    key(3'd0); doWrite(18'h05555, 8'h90);
    key(3'd0); doWrite(18'h05555, 8'hA0);
    doReset();
    @(negedge clk);
    chk("R12 idMode cleared", 32'(idMode), 32'(0));
    settle();
    doWrite(18'h00444, 8'h12);
    chk("R12 sequence abandoned", 32'(pulses()), 32'(0));

    // Random command scripts with occasional corruption
    for (int it = 0; it < 80; it++) begin
      int cmd;
      int bad;
      cmd = int'($urandom % 7);
      bad = 0;
      if (cmd != 6 && ($urandom % 4) == 0) begin
        if (cmd >= 1 && cmd <= 3) bad = 1 + int'($urandom % 6);
        else                      bad = 1 + int'($urandom % 3);
      end
      sendSeq(cmd, bad);
      for (int k = 0; k < 2; k++) begin
        logic [AW-1:0] ra;
        ra = AW'($urandom % 4);
        bootLocked = 1'($urandom);
        addr = ra;
        #1 chk("R7 random id read", 32'(idData), 32'(expId(modelId, ra, bootLocked)));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule